// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block watches the pipeline-register fields of a 32-bit, five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It produces four things. The first is the operand selects for the execute-stage ALU. The second is the operand selects for the equality comparator that resolves branches in decode. The third is a stall request, which holds the PC and the fetch/decode register and puts a bubble into the decode/execute register. The fourth is a flush that squashes the one sequential instruction fetched after a taken branch.

The block has no state. All of its outputs are combinational functions of the fields it observes. Two-cycle stalls, such as a branch waiting on a load, come from the pipeline advancing while the stall stays asserted. Register writes happen in the write-back stage. The register file is assumed to bypass write-first from write-back, so decode never needs a forwarding path from that stage. Register 0 reads as zero and is never treated as a dependence.

Top module: `hzd_fwd_unit`

## Requirements
- R1: An execute operand select is 2'b10 (take the memory-stage result) when the memory stage writes a nonzero destination equal to that operand's source register.
- R2: If R1 does not apply, the select is 2'b01 (take the write-back result) when write-back writes a nonzero destination equal to the source. Otherwise it is 2'b00 (register file). The encoding 2'b11 never appears.
- R3: A source or destination equal to register 0 never produces a forwarding select other than 2'b00 and never produces a stall.
- R4: A load in execute that writes a nonzero destination equal to either decode source raises stall, whether or not decode holds a branch.
- R5: A decode branch raises stall when a non-load instruction in execute writes a nonzero destination equal to either branch source.
- R6: A decode branch raises stall when a load in the memory stage writes a nonzero destination equal to either branch source. Together with R4, a branch that depends on a load in execute stalls for two consecutive cycles.
- R7: A branch comparator select is 1 (take the memory-stage result) only when the memory stage holds a non-load that writes a nonzero destination equal to that branch source. Otherwise it is 0 (register file with write-first bypass).
- R8: flush equals branch-in-decode AND branch-taken AND NOT stall.
- R9: No other condition raises stall. In particular, a non-branch decode instruction does not stall for an ALU result in execute, or for anything in the memory or write-back stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the decode instruction |
| id_src_b | input | REG_AW | Second source register of the decode instruction |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch comparison in decode resolved as taken |
| ex_src_a | input | REG_AW | First source register of the execute instruction |
| ex_src_b | input | REG_AW | Second source register of the execute instruction |
| ex_dst | input | REG_AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_AW | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| ex_fwd_a | output | 2 | Execute operand A select (00 file, 01 write-back, 10 memory) |
| ex_fwd_b | output | 2 | Execute operand B select (same encoding) |
| br_fwd_a | output | 1 | Branch comparator operand A select (1 = memory stage) |
| br_fwd_b | output | 1 | Branch comparator operand B select (1 = memory stage) |
| stall | output | 1 | Hold PC and fetch/decode, bubble into decode/execute |
| flush | output | 1 | Squash the instruction behind a taken branch |

## Verification
The assertions assume that the load flag is only meaningful together with its write enable. They also assume that id_br_taken matters only while id_branch is high. The stimulus keeps both assumptions by clearing each load flag whenever the matching write enable is clear. The random stimulus draws register numbers from 0 to 3, so that matches, register-0 cases and simultaneous memory and write-back hits occur often. Directed sequences cover a load-use hazard, a branch that waits on a load in execute and then in memory, priority between stages, and a flush that is held off while the branch is stalled.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WB  = 2'b01,
      FWD_MEM = 2'b10
   } ex_fwd_e;
endpackage

// File: rtl/hzd_dst_match.sv
// One comparison: does a writing, nonzero destination feed this source?
module hzd_dst_match #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] dst,
   input  logic              wen,
   output logic              hit
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;
   always_comb begin
      hit = wen && (dst != ZERO_REG) && (dst == src);
   end
endmodule

// File: rtl/hzd_ex_fwd.sv
// Execute-stage operand select: memory stage wins over write-back.
module hzd_ex_fwd #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wen,
   output hzd_pkg::ex_fwd_e  sel
);
   logic mem_hit, wb_hit;

   hzd_dst_match #(.REG_AW(REG_AW)) u_mem (
      .src(src), .dst(mem_dst), .wen(mem_wen), .hit(mem_hit));
   hzd_dst_match #(.REG_AW(REG_AW)) u_wb (
      .src(src), .dst(wb_dst), .wen(wb_wen), .hit(wb_hit));

   always_comb begin
      if (mem_hit)     sel = hzd_pkg::FWD_MEM;
      else if (wb_hit) sel = hzd_pkg::FWD_WB;
      else             sel = hzd_pkg::FWD_RF;
   end
endmodule

// File: rtl/hzd_br_fwd.sv
// Branch comparator select: only a finished ALU result in the memory stage.
module hzd_br_fwd #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   input  logic              mem_load,
   output logic              sel
);
   logic alu_wen;
   assign alu_wen = mem_wen & ~mem_load;

   hzd_dst_match #(.REG_AW(REG_AW)) u_mem (
      .src(src), .dst(mem_dst), .wen(alu_wen), .hit(sel));
endmodule

// File: rtl/hzd_stall_ctl.sv
// Stall decision for the decode instruction.
module hzd_stall_ctl #(
   parameter int REG_AW  = 5,
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
   input  logic                           id_branch,
   input  logic [REG_AW-1:0]              ex_dst,
   input  logic                           ex_wen,
   input  logic                           ex_load,
   input  logic [REG_AW-1:0]              mem_dst,
   input  logic                           mem_wen,
   input  logic                           mem_load,
   output logic                           stall
);
   logic [NUM_SRC-1:0] ex_hit, mem_hit;
   logic               mem_ld_wen;

   assign mem_ld_wen = mem_wen & mem_load;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      hzd_dst_match #(.REG_AW(REG_AW)) u_ex (
         .src(id_src[s]), .dst(ex_dst), .wen(ex_wen), .hit(ex_hit[s]));
      hzd_dst_match #(.REG_AW(REG_AW)) u_mem (
         .src(id_src[s]), .dst(mem_dst), .wen(mem_ld_wen), .hit(mem_hit[s]));
   end

   logic load_use, br_on_ex, br_on_mem_load;
   always_comb begin
      load_use       = ex_load && (|ex_hit);
      br_on_ex       = id_branch && (|ex_hit);
      br_on_mem_load = id_branch && (|mem_hit);
      stall          = load_use || br_on_ex || br_on_mem_load;
   end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit #(
   parameter int REG_AW = 5
) (
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              id_branch,
   input  logic              id_br_taken,
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_wen,
   input  logic              ex_load,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   input  logic              mem_load,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wen,
   output logic [1:0]        ex_fwd_a,
   output logic [1:0]        ex_fwd_b,
   output logic              br_fwd_a,
   output logic              br_fwd_b,
   output logic              stall,
   output logic              flush
);
   localparam int NUM_SRC = 2;

   if (REG_AW < 2 || REG_AW > 8) begin : g_bad_aw
      $error("hzd_fwd_unit: REG_AW must lie in 2..8");
   end

   logic [NUM_SRC-1:0][REG_AW-1:0] id_src, ex_src;
   hzd_pkg::ex_fwd_e [NUM_SRC-1:0] ex_sel;
   logic [NUM_SRC-1:0]             br_sel;

   assign id_src = {id_src_b, id_src_a};
   assign ex_src = {ex_src_b, ex_src_a};

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
      hzd_ex_fwd #(.REG_AW(REG_AW)) u_exf (
         .src(ex_src[s]), .mem_dst(mem_dst), .mem_wen(mem_wen),
         .wb_dst(wb_dst), .wb_wen(wb_wen), .sel(ex_sel[s]));
      hzd_br_fwd #(.REG_AW(REG_AW)) u_brf (
         .src(id_src[s]), .mem_dst(mem_dst), .mem_wen(mem_wen),
         .mem_load(mem_load), .sel(br_sel[s]));
   end

   hzd_stall_ctl #(.REG_AW(REG_AW), .NUM_SRC(NUM_SRC)) u_stl (
      .id_src(id_src), .id_branch(id_branch),
      .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
      .stall(stall));

   assign ex_fwd_a = ex_sel[0];
   assign ex_fwd_b = ex_sel[1];
   assign br_fwd_a = br_sel[0];
   assign br_fwd_b = br_sel[1];
   assign flush    = id_branch & id_br_taken & ~stall;
endmodule

// File: rtl/hzd_fwd_chk.sv
module hzd_fwd_chk #(
   parameter int REG_AW = 5
) (
   input logic [REG_AW-1:0] id_src_a,
   input logic [REG_AW-1:0] id_src_b,
   input logic              id_branch,
   input logic              id_br_taken,
   input logic [REG_AW-1:0] ex_src_a,
   input logic [REG_AW-1:0] ex_dst,
   input logic              ex_wen,
   input logic              ex_load,
   input logic [REG_AW-1:0] mem_dst,
   input logic              mem_wen,
   input logic              mem_load,
   input logic [1:0]        ex_fwd_a,
   input logic [1:0]        ex_fwd_b,
   input logic              br_fwd_a,
   input logic              br_fwd_b,
   input logic              stall,
   input logic              flush
);
   localparam logic [REG_AW-1:0] Z = '0;

   always_comb begin
      // R2: the unused select code never appears
      p_no_code3_r2: assert (ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11);
      // R3: register 0 source always reads the register file
      p_zero_src_r3: assert (ex_src_a != Z || ex_fwd_a == 2'b00);
      // R1: a memory-stage hit takes the memory path
      p_mem_wins_r1: assert (!(mem_wen && mem_dst != Z && mem_dst == ex_src_a)
                             || ex_fwd_a == 2'b10);
      // R4: load-use dependence stalls
      p_load_use_r4: assert (!(ex_load && ex_wen && ex_dst != Z &&
                               (ex_dst == id_src_a || ex_dst == id_src_b)) || stall);
      // R7: comparator never forwards a load still in memory
      p_br_no_load_r7: assert (!((br_fwd_a || br_fwd_b) && mem_load));
      // R8: flush and stall never together; flush needs a taken branch
      p_flush_r8: assert (!flush || (!stall && id_branch && id_br_taken));
   end
endmodule

bind hzd_fwd_unit hzd_fwd_chk #(.REG_AW(REG_AW)) u_chk (
   .id_src_a(id_src_a), .id_src_b(id_src_b), .id_branch(id_branch),
   .id_br_taken(id_br_taken), .ex_src_a(ex_src_a), .ex_dst(ex_dst),
   .ex_wen(ex_wen), .ex_load(ex_load), .mem_dst(mem_dst), .mem_wen(mem_wen),
   .mem_load(mem_load), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
   .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b), .stall(stall), .flush(flush));

// File: tb/sim_hzd_fwd_unit.sv
module sim_hzd_fwd_unit;
   localparam int AW = 5;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
   logic id_branch, id_br_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
   logic [1:0] ex_fwd_a, ex_fwd_b;
   logic br_fwd_a, br_fwd_b, stall, flush;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   hzd_fwd_unit #(.REG_AW(AW)) u0 (.*);

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic bit hit(logic [AW-1:0] s, logic [AW-1:0] d, logic w);
      return w && d != 0 && d == s;
   endfunction

   function automatic int m_ex(logic [AW-1:0] s);
      if (hit(s, mem_dst, mem_wen)) return 2;
      if (hit(s, wb_dst, wb_wen)) return 1;
      return 0;
   endfunction

   function automatic int m_br(logic [AW-1:0] s);
      return int'(hit(s, mem_dst, mem_wen && !mem_load));
   endfunction

   function automatic int m_stall();
      bit exa = hit(id_src_a, ex_dst, ex_wen) || hit(id_src_b, ex_dst, ex_wen);
      bit mla = hit(id_src_a, mem_dst, mem_wen && mem_load) ||
                hit(id_src_b, mem_dst, mem_wen && mem_load);
      return int'((ex_load && exa) || (id_branch && exa) || (id_branch && mla));
   endfunction

   task automatic clear();
      {id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst} = '0;
      {id_branch, id_br_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(string tag);
      #2;
      chk({tag, " R1/R2 ex_fwd_a"}, int'(ex_fwd_a), m_ex(ex_src_a));
      chk({tag, " R1/R2 ex_fwd_b"}, int'(ex_fwd_b), m_ex(ex_src_b));
      chk({tag, " R7 br_fwd_a"}, int'(br_fwd_a), m_br(id_src_a));
      chk({tag, " R7 br_fwd_b"}, int'(br_fwd_b), m_br(id_src_b));
      chk({tag, " R4/R5/R6/R9 stall"}, int'(stall), m_stall());
      chk({tag, " R8 flush"}, int'(flush),
          int'(id_branch && id_br_taken && m_stall() == 0));
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      clear();
      step();
      // idle state: everything zero
      #2;
      chk("idle ex_fwd_a", int'(ex_fwd_a), 0);
      chk("idle stall", int'(stall), 0);
      chk("idle flush", int'(flush), 0);

      // R1 priority: both mem and wb match
      step(); clear();
      ex_src_a = 7; mem_dst = 7; mem_wen = 1; wb_dst = 7; wb_wen = 1;
      ex_src_b = 9; wb_dst = 7;
      #2; chk("R1 mem beats wb", int'(ex_fwd_a), 2);
      chk("R2 no match b", int'(ex_fwd_b), 0);

      // R2 write-back only
      step(); clear();
      ex_src_b = 12; wb_dst = 12; wb_wen = 1;
      #2; chk("R2 wb only", int'(ex_fwd_b), 1);

      // R3 register 0 never forwards nor stalls
      step(); clear();
      ex_src_a = 0; mem_dst = 0; mem_wen = 1; wb_wen = 1;
      ex_dst = 0; ex_wen = 1; ex_load = 1; id_branch = 1; id_br_taken = 1;
      #2; chk("R3 zero fwd", int'(ex_fwd_a), 0);
      chk("R3 zero stall", int'(stall), 0);
      chk("R3 flush with no stall", int'(flush), 1);

      // R4 load-use on source b
      step(); clear();
      id_src_b = 4; ex_dst = 4; ex_wen = 1; ex_load = 1;
      #2; chk("R4 load-use", int'(stall), 1);

      // R9 ALU in execute, non-branch: no stall
      step(); clear();
      id_src_a = 4; ex_dst = 4; ex_wen = 1;
      mem_dst = 4; mem_wen = 1; mem_load = 1;
      #2; chk("R9 no stall non-branch", int'(stall), 0);

      // R5 branch on ALU in execute, taken: stall, flush held off
      step(); clear();
      id_branch = 1; id_br_taken = 1; id_src_a = 6; ex_dst = 6; ex_wen = 1;
      #2; chk("R5 branch on ex alu", int'(stall), 1);
      chk("R8 flush suppressed", int'(flush), 0);

      // R6 two-cycle sequence: load in ex, then in mem, then in wb
      step(); clear();
      id_branch = 1; id_br_taken = 1; id_src_b = 10;
      ex_dst = 10; ex_wen = 1; ex_load = 1;
      #2; chk("R6 cycle1 stall", int'(stall), 1);
      step();
      ex_dst = 0; ex_wen = 0; ex_load = 0;
      mem_dst = 10; mem_wen = 1; mem_load = 1;
      #2; chk("R6 cycle2 stall", int'(stall), 1);
      chk("R7 no fwd of load", int'(br_fwd_b), 0);
      step();
      mem_dst = 0; mem_wen = 0; mem_load = 0; wb_dst = 10; wb_wen = 1;
      #2; chk("R6 cycle3 released", int'(stall), 0);
      chk("R8 flush after release", int'(flush), 1);
      chk("R7 regfile bypass", int'(br_fwd_b), 0);

      // R7 ALU in memory forwards to comparator, no stall
      step(); clear();
      id_branch = 1; id_src_a = 3; mem_dst = 3; mem_wen = 1;
      #2; chk("R7 br fwd from mem", int'(br_fwd_a), 1);
      chk("R9 no stall alu in mem", int'(stall), 0);
      chk("R8 not taken no flush", int'(flush), 0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         step();
         id_src_a = AW'($urandom_range(0, 3)); id_src_b = AW'($urandom_range(0, 3));
         ex_src_a = AW'($urandom_range(0, 3)); ex_src_b = AW'($urandom_range(0, 3));
         ex_dst = AW'($urandom_range(0, 3)); mem_dst = AW'($urandom_range(0, 3));
         wb_dst = AW'($urandom_range(0, 3));
         id_branch = 1'($urandom_range(0, 1)); id_br_taken = 1'($urandom_range(0, 1));
         ex_wen = 1'($urandom_range(0, 1)); mem_wen = 1'($urandom_range(0, 1));
         wb_wen = 1'($urandom_range(0, 1));
         ex_load = ex_wen & 1'($urandom_range(0, 1));
         mem_load = mem_wen & 1'($urandom_range(0, 1));
         check_all("rand");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule